// File: doc/BRIEF.md
# Interrupt-Aware Fetch-Execute Sequencer

This block is the control unit of a simple processor. It holds the program counter and the instruction register, and it drives a single-word memory port. From reset it reads the instruction at a fixed start address and then loops. Each pass hands the instruction register to an external execute stage, steps the program counter, and reads the next word. The execute stage owns all decoding. It returns a done pulse together with a few control lines: halt, trap with a small argument, interrupt-enable set and clear, and return to user mode.

Two redirections are built into the sequencer. A hardware interrupt is checked once after every instruction read. If the request is high and interrupts are enabled, the sequencer does the following in order:
1. Masks further interrupts.
2. Writes the address of the instruction it just read (and has not executed) into memory word 0.
3. Reads the new program counter from memory word 1.
4. Reads the instruction at that address.

A trap from the execute stage forces supervisor mode and takes its new program counter from word `TRAP_BASE + n`. No interrupt check can fall between the mode change and the new address. A halt from the execute stage parks the sequencer for good.

Top module: `fetch_exec_seq`

## Requirements
- R1: While reset is low, and on the first cycle after its release, `pc` equals `START_ADDR` (default 256), `int_en` is 0, `sup_mode` is 1, `halted` is 0 and `ex_start` is 0. The first memory access is a read at `START_ADDR`.
- R2: A read at `pc` loads the returned word into `ex_instr`. `ex_start` then stays high until `ex_done`, and no memory request is made while `ex_start` is high.
- R3: When `ex_done` comes without halt or trap, `pc` advances by `STEP` (default 1), and the next memory access is a read at the new `pc`.
- R4: If `irq` is high while `int_en` is 0, the interrupt is ignored. Memory word 0 is not written, and the accesses follow the plain program order.
- R5: With `irq` and `int_en` both high after a read, `int_en` is cleared before any write. The next accesses are, in order: a write of the unexecuted instruction's address to word 0, a read of word 1, and a read at the address returned by word 1. Nothing is executed between these accesses.
- R6: `ex_done` with `ex_trap` (and no `ex_halt`) sets `sup_mode` to 1. The next accesses are a read of word `TRAP_BASE + ex_trap_arg` (default base 1000), then a read at the returned address.
- R7: `ex_done` with `ex_halt` raises `halted`, which then stays high. `mem_req` and `ex_start` stay low from then on, and `pc` keeps the address of the halting instruction.
- R8: At `ex_done`, `ex_ie_set` sets `int_en` and `ex_ie_clr` clears it, with clear winning when both are high. `ex_user_ret` clears `sup_mode` unless a trap is taken in the same cycle.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. Each access completes on exactly one acknowledge.
- R10: When a trap completes while an interrupt is pending and enabled, the trap is taken first. The interrupt is then taken after the read of the trap handler's first instruction, and that handler address is the value saved in word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq | input | 1 | Hardware interrupt request, level |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| ex_start | output | 1 | `ex_instr` is waiting for execution |
| ex_instr | output | DW | Instruction register |
| ex_done | input | 1 | Execute stage finished the instruction |
| ex_halt | input | 1 | With `ex_done`: stop the loop |
| ex_trap | input | 1 | With `ex_done`: take a trap |
| ex_trap_arg | input | TW | Trap number n |
| ex_ie_set | input | 1 | With `ex_done`: enable interrupts |
| ex_ie_clr | input | 1 | With `ex_done`: disable interrupts |
| ex_user_ret | input | 1 | With `ex_done`: return to user mode |
| pc | output | AW | Program counter |
| int_en | output | 1 | Interrupt-enable flag |
| sup_mode | output | 1 | 1 = supervisor mode |
| halted | output | 1 | Sequencer parked after a halt |

## Verification
The risky overlap is a trap completing in the same cycle that an enabled interrupt request arrives. Both events want to redirect the program counter, and only one ordering is correct. The bench's execute model raises `irq` on the very edge where it reports the trap as done, with interrupts already enabled. The memory trace must then show the trap vector read, the handler's first instruction read, the save of that handler address to word 0, and only then the read of word 1. A second overlap is enable and disable requested together in one `ex_done`; there the flag must end cleared.

// File: rtl/fes_pkg.sv
package fes_pkg;
  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_CHECK = 3'd1,
    ST_EXEC  = 3'd2,
    ST_SAVE  = 3'd3,
    ST_VECT  = 3'd4,
    ST_TRAP  = 3'd5,
    ST_HALT  = 3'd6
  } seq_state_e;
endpackage

// File: rtl/fes_ctrl.sv
module fes_ctrl
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_ack,
  input  logic       irq,
  input  logic       int_en,
  input  logic       ex_done,
  input  logic       ex_halt,
  input  logic       ex_trap,
  output seq_state_e state
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_FETCH: if (mem_ack) nxt = ST_CHECK;
      ST_CHECK: nxt = (irq && int_en) ? ST_SAVE : ST_EXEC;
      ST_EXEC: begin
        if (ex_done) begin
          if (ex_halt)      nxt = ST_HALT;
          else if (ex_trap) nxt = ST_TRAP;
          else              nxt = ST_FETCH;
        end
      end
      ST_SAVE:  if (mem_ack) nxt = ST_VECT;
      ST_VECT:  if (mem_ack) nxt = ST_FETCH;
      ST_TRAP:  if (mem_ack) nxt = ST_FETCH;
      ST_HALT:  nxt = ST_HALT;
      default:  nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_HALT |=> state == ST_HALT); // R7
  AST_MASKED_NO_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK && !int_en) |=> state != ST_SAVE); // R4
  AST_SAVE_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == ST_SAVE) |-> $past(state) == ST_CHECK); // R5
endmodule

// File: rtl/fes_flags.sv
module fes_flags
  import fes_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state,
  input  logic       irq,
  input  logic       ex_done,
  input  logic       ex_halt,
  input  logic       ex_trap,
  input  logic       ex_ie_set,
  input  logic       ex_ie_clr,
  input  logic       ex_user_ret,
  output logic       int_en,
  output logic       sup_mode
);
  logic take_irq, retire, ie_en, ie_d, sup_en, sup_d;

  assign take_irq = (state == ST_CHECK) && irq && int_en;
  assign retire   = (state == ST_EXEC) && ex_done;

  always_comb begin
    ie_en = 1'b0;
    ie_d  = int_en;
    if (take_irq) begin
      ie_en = 1'b1;
      ie_d  = 1'b0;
    end else if (retire && (ex_ie_set || ex_ie_clr)) begin
      ie_en = 1'b1;
      ie_d  = !ex_ie_clr;
    end
    sup_en = 1'b0;
    sup_d  = sup_mode;
    if (retire && ex_trap && !ex_halt) begin
      sup_en = 1'b1;
      sup_d  = 1'b1;
    end else if (retire && ex_user_ret) begin
      sup_en = 1'b1;
      sup_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en   <= 1'b0;
      sup_mode <= 1'b1;
    end else begin
      if (ie_en)  int_en   <= ie_d;
      if (sup_en) sup_mode <= sup_d;
    end
  end

  AST_SAVE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SAVE |-> !int_en); // R5
  AST_TRAP_SUP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && ex_done && ex_trap && !ex_halt) |=> sup_mode); // R6
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && ex_done && ex_ie_clr) |=> !int_en); // R8
endmodule

// File: rtl/fes_pc_unit.sv
module fes_pc_unit
  import fes_pkg::*;
#(
  parameter int             AW         = 16,
  parameter int             DW         = 16,
  parameter int             TW         = 4,
  parameter logic [AW-1:0]  START_ADDR = 16'h0100,
  parameter logic [AW-1:0]  STEP       = 16'd1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata,
  input  logic          ex_done,
  input  logic          ex_halt,
  input  logic          ex_trap,
  input  logic [TW-1:0] ex_trap_arg,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ir,
  output logic [TW-1:0] trap_idx
);
  logic          retire, pc_en, ir_en, idx_en;
  logic [AW-1:0] pc_d;

  assign retire = (state == ST_EXEC) && ex_done && !ex_halt;
  assign ir_en  = (state == ST_FETCH) && mem_ack;
  assign idx_en = retire && ex_trap;

  always_comb begin
    pc_en = 1'b0;
    pc_d  = pc;
    if (retire && !ex_trap) begin
      pc_en = 1'b1;
      pc_d  = pc + STEP;
    end else if ((state == ST_VECT || state == ST_TRAP) && mem_ack) begin
      pc_en = 1'b1;
      pc_d  = mem_rdata[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= START_ADDR;
      ir       <= '0;
      trap_idx <= '0;
    end else begin
      if (pc_en)  pc       <= pc_d;
      if (ir_en)  ir       <= mem_rdata;
      if (idx_en) trap_idx <= ex_trap_arg;
    end
  end

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && ex_done && !ex_halt && !ex_trap) |=> pc == $past(pc) + STEP); // R3
  AST_PC_HOLD_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EXEC && !ex_done) |=> $stable(pc)); // R2
endmodule

// File: rtl/fes_mem_sel.sv
module fes_mem_sel
  import fes_pkg::*;
#(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter int            TW        = 4,
  parameter logic [AW-1:0] TRAP_BASE = 16'd1000
) (
  input  seq_state_e    state,
  input  logic [AW-1:0] pc,
  input  logic [TW-1:0] trap_idx,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam logic [AW-1:0] SAVE_WORD = '0;
  localparam logic [AW-1:0] VECT_WORD = {{(AW-1){1'b0}}, 1'b1};

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = pc;
    mem_wdata = '0;
    case (state)
      ST_FETCH: mem_req = 1'b1;
      ST_SAVE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = SAVE_WORD;
        mem_wdata = DW'(pc);
      end
      ST_VECT: begin
        mem_req  = 1'b1;
        mem_addr = VECT_WORD;
      end
      ST_TRAP: begin
        mem_req  = 1'b1;
        mem_addr = TRAP_BASE + {{(AW-TW){1'b0}}, trap_idx};
      end
      default: mem_req = 1'b0;
    endcase
  end
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
  import fes_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 16,
  parameter int            TW         = 4,
  parameter logic [AW-1:0] START_ADDR = 16'h0100,
  parameter logic [AW-1:0] STEP       = 16'd1,
  parameter logic [AW-1:0] TRAP_BASE  = 16'd1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          ex_start,
  output logic [DW-1:0] ex_instr,
  input  logic          ex_done,
  input  logic          ex_halt,
  input  logic          ex_trap,
  input  logic [TW-1:0] ex_trap_arg,
  input  logic          ex_ie_set,
  input  logic          ex_ie_clr,
  input  logic          ex_user_ret,
  output logic [AW-1:0] pc,
  output logic          int_en,
  output logic          sup_mode,
  output logic          halted
);
  seq_state_e    state;
  logic [TW-1:0] trap_idx;

  fes_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .mem_ack(mem_ack), .irq(irq), .int_en(int_en),
    .ex_done(ex_done), .ex_halt(ex_halt), .ex_trap(ex_trap), .state(state)
  );

  fes_flags u_flags (
    .clk(clk), .rst_n(rst_n), .state(state), .irq(irq), .ex_done(ex_done),
    .ex_halt(ex_halt), .ex_trap(ex_trap), .ex_ie_set(ex_ie_set),
    .ex_ie_clr(ex_ie_clr), .ex_user_ret(ex_user_ret),
    .int_en(int_en), .sup_mode(sup_mode)
  );

  fes_pc_unit #(.AW(AW), .DW(DW), .TW(TW), .START_ADDR(START_ADDR), .STEP(STEP)) u_pc (
    .clk(clk), .rst_n(rst_n), .state(state), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ex_done(ex_done), .ex_halt(ex_halt), .ex_trap(ex_trap), .ex_trap_arg(ex_trap_arg),
    .pc(pc), .ir(ex_instr), .trap_idx(trap_idx)
  );

  fes_mem_sel #(.AW(AW), .DW(DW), .TW(TW), .TRAP_BASE(TRAP_BASE)) u_msel (
    .state(state), .pc(pc), .trap_idx(trap_idx), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  assign ex_start = (state == ST_EXEC);
  assign halted   = (state == ST_HALT);

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_START_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ex_start |-> !mem_req); // R2
  AST_WRITE_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == '0 && !int_en)); // R5
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_req && !ex_start && $stable(pc))); // R7
endmodule

// File: tb/fetch_exec_seq_tb.sv
`timescale 1ns/1ps
module fetch_exec_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq, irq_task, irq_trig, trig_en;
  logic        mem_req, mem_we, mem_ack;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        ex_start, ex_done, ex_halt, ex_trap, ex_ie_set, ex_ie_clr, ex_user_ret;
  logic [3:0]  ex_trap_arg;
  logic [15:0] ex_instr, pc;
  logic        int_en, sup_mode, halted;

  logic [15:0] mem [0:2047];
  logic        tr_we   [0:63];
  logic [15:0] tr_addr [0:63];
  logic [15:0] tr_dat  [0:63];
  int          tr_n;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;
  assign irq = irq_task | irq_trig;

  fetch_exec_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .ex_start(ex_start), .ex_instr(ex_instr), .ex_done(ex_done), .ex_halt(ex_halt),
    .ex_trap(ex_trap), .ex_trap_arg(ex_trap_arg), .ex_ie_set(ex_ie_set),
    .ex_ie_clr(ex_ie_clr), .ex_user_ret(ex_user_ret), .pc(pc), .int_en(int_en),
    .sup_mode(sup_mode), .halted(halted)
  );

  // memory: acknowledge one cycle after a request, log every access
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      tr_n    <= 0;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[10:0]];
      if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
      if (tr_n < 64) begin
        tr_we[tr_n]   <= mem_we;
        tr_addr[tr_n] <= mem_addr;
        tr_dat[tr_n]  <= mem_we ? mem_wdata : mem[mem_addr[10:0]];
      end
      tr_n <= tr_n + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // execute model, bench encoding in bits 15:12:
  // 0 nop, 1 halt, 2 trap (n in bits 3:0), 3 ie set, 4 ie clr, 5 user return, 6 ie set+clr
  always @(posedge clk) begin
    if (!rst_n) begin
      ex_done <= 1'b0; ex_halt <= 1'b0; ex_trap <= 1'b0; ex_trap_arg <= '0;
      ex_ie_set <= 1'b0; ex_ie_clr <= 1'b0; ex_user_ret <= 1'b0; irq_trig <= 1'b0;
    end else if (ex_start && !ex_done) begin
      ex_done     <= 1'b1;
      ex_halt     <= ex_instr[15:12] == 4'h1;
      ex_trap     <= ex_instr[15:12] == 4'h2;
      ex_trap_arg <= ex_instr[3:0];
      ex_ie_set   <= ex_instr[15:12] == 4'h3 || ex_instr[15:12] == 4'h6;
      ex_ie_clr   <= ex_instr[15:12] == 4'h4 || ex_instr[15:12] == 4'h6;
      ex_user_ret <= ex_instr[15:12] == 4'h5;
      if (ex_instr[15:12] == 4'h2 && trig_en) irq_trig <= 1'b1;
    end else begin
      ex_done <= 1'b0; ex_halt <= 1'b0; ex_trap <= 1'b0;
      ex_ie_set <= 1'b0; ex_ie_clr <= 1'b0; ex_user_ret <= 1'b0;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_acc(input string req, input int idx, input logic we, input logic [15:0] addr);
    chk(req, $sformatf("access %0d kind", idx), {31'd0, tr_we[idx]}, {31'd0, we});
    chk(req, $sformatf("access %0d addr", idx), {16'd0, tr_addr[idx]}, {16'd0, addr});
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
  endtask

  task automatic run_prog();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (halted) break;
    end
  endtask

  task automatic t_reset();
    clear_mem();
    irq_task = 1'b0; trig_en = 1'b0;
    mem[256] = 16'h1000;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", {16'd0, pc}, 32'd256);
    chk("R1", "int_en in reset", {31'd0, int_en}, 32'd0);
    chk("R1", "sup_mode in reset", {31'd0, sup_mode}, 32'd1);
    chk("R1", "halted in reset", {31'd0, halted}, 32'd0);
    chk("R1", "ex_start in reset", {31'd0, ex_start}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc after release", {16'd0, pc}, 32'd256);
    repeat (10) @(negedge clk);
    chk_acc("R1", 0, 1'b0, 16'd256);
  endtask

  task automatic t_straight();
    clear_mem();
    irq_task = 1'b0; trig_en = 1'b0;
    mem[256] = 16'h0000; mem[257] = 16'h0000; mem[258] = 16'h1000;
    run_prog();
    chk("R3", "access count", tr_n, 32'd3);
    chk_acc("R3", 0, 1'b0, 16'd256);
    chk_acc("R3", 1, 1'b0, 16'd257);
    chk_acc("R3", 2, 1'b0, 16'd258);
    chk("R2", "ex_instr holds fetched word", {16'd0, ex_instr}, 32'h1000);
    chk("R7", "halted", {31'd0, halted}, 32'd1);
    chk("R7", "pc at halting instruction", {16'd0, pc}, 32'd258);
    repeat (20) @(negedge clk);
    chk("R7", "no access after halt", tr_n, 32'd3);
    chk("R7", "ex_start low after halt", {31'd0, ex_start}, 32'd0);
  endtask

  task automatic t_masked();
    clear_mem();
    irq_task = 1'b1; trig_en = 1'b0;
    mem[1] = 16'h0200; mem[256] = 16'h0000; mem[257] = 16'h0000; mem[258] = 16'h1000;
    run_prog();
    chk("R4", "access count with masked irq", tr_n, 32'd3);
    chk("R4", "word 0 untouched", {16'd0, mem[0]}, 32'd0);
    chk("R4", "pc after masked run", {16'd0, pc}, 32'd258);
    irq_task = 1'b0;
  endtask

  task automatic t_irq();
    clear_mem();
    irq_task = 1'b1; trig_en = 1'b0;
    mem[1] = 16'h0200; mem[256] = 16'h3000; mem[257] = 16'h0000; mem[512] = 16'h1000;
    run_prog();
    chk("R9", "one trace entry per access", tr_n, 32'd5);
    chk_acc("R5", 0, 1'b0, 16'd256);
    chk_acc("R5", 1, 1'b0, 16'd257);
    chk_acc("R5", 2, 1'b1, 16'd0);
    chk("R5", "saved pc is unexecuted address", {16'd0, tr_dat[2]}, 32'd257);
    chk_acc("R5", 3, 1'b0, 16'd1);
    chk_acc("R5", 4, 1'b0, 16'd512);
    chk("R5", "word 0 contents", {16'd0, mem[0]}, 32'd257);
    chk("R5", "interrupts masked after entry", {31'd0, int_en}, 32'd0);
    chk("R5", "pc at vector target", {16'd0, pc}, 32'd512);
    irq_task = 1'b0;
  endtask

  task automatic t_trap();
    clear_mem();
    irq_task = 1'b0; trig_en = 1'b0;
    mem[1003] = 16'h0300; mem[256] = 16'h5000; mem[257] = 16'h2003; mem[768] = 16'h1000;
    run_prog();
    chk("R6", "access count", tr_n, 32'd4);
    chk_acc("R6", 2, 1'b0, 16'd1003);
    chk_acc("R6", 3, 1'b0, 16'd768);
    chk("R6", "supervisor after trap", {31'd0, sup_mode}, 32'd1);
    chk("R6", "pc at handler", {16'd0, pc}, 32'd768);
  endtask

  task automatic t_flags();
    clear_mem();
    irq_task = 1'b0; trig_en = 1'b0;
    mem[256] = 16'h3000; mem[257] = 16'h1000;
    run_prog();
    chk("R8", "ie set", {31'd0, int_en}, 32'd1);
    chk("R8", "still supervisor", {31'd0, sup_mode}, 32'd1);
    clear_mem();
    mem[256] = 16'h3000; mem[257] = 16'h5000; mem[258] = 16'h6000; mem[259] = 16'h1000;
    run_prog();
    chk("R8", "clear wins over set", {31'd0, int_en}, 32'd0);
    chk("R8", "user mode after return", {31'd0, sup_mode}, 32'd0);
  endtask

  task automatic t_trap_irq();
    clear_mem();
    irq_task = 1'b0; trig_en = 1'b1;
    mem[1] = 16'h0200; mem[1002] = 16'h0300;
    mem[256] = 16'h3000; mem[257] = 16'h2002; mem[768] = 16'h0000; mem[512] = 16'h1000;
    run_prog();
    chk("R10", "access count", tr_n, 32'd7);
    chk_acc("R10", 2, 1'b0, 16'd1002);
    chk_acc("R10", 3, 1'b0, 16'd768);
    chk_acc("R10", 4, 1'b1, 16'd0);
    chk_acc("R10", 5, 1'b0, 16'd1);
    chk_acc("R10", 6, 1'b0, 16'd512);
    chk("R10", "saved handler address", {16'd0, mem[0]}, 32'd768);
    chk("R10", "supervisor kept", {31'd0, sup_mode}, 32'd1);
    trig_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    irq_task = 1'b0;
    trig_en  = 1'b0;
    t_reset();
    t_straight();
    t_masked();
    t_irq();
    t_trap();
    t_flags();
    t_trap_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule